// File: doc/BRIEF.md
# IPv4 Longest-Prefix Forwarding Stage

This block is one match-action stage of a packet pipeline. It compares the destination address of each IPv4 header against a small table of prefix entries and picks the matching entry with the longest prefix. It then carries out that entry's action. A forward action sets the egress port and lowers the TTL by one. A broadcast action flags the packet for broadcast egress and also lowers the TTL. A table miss, an explicit drop action, an expiring TTL or a non-IPv4 header all produce a drop.

Software or a control agent fills the table one entry per clock through a write port that carries an index, a prefix, a prefix length, an action code, a port and a valid bit. The stage accepts one header every clock. Its result comes out of a register one clock later, together with an output valid strobe.

Top module: `ipv4_lpm_stage`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and a new header can be taken every cycle.
- R2: An entry matches when its valid bit is set and the leading `len` bits of the destination equal those of its prefix. A length of 0 matches every address, and a length above 32 behaves as 32.
- R3: When more than one entry matches, the entry with the greatest effective length is used. On equal lengths, the lowest index is used.
- R4: Action code 0 (forward) gives `out_port` = entry port, `out_bcast` = 0, `out_drop` = 0 and `out_ttl` = input TTL − 1.
- R5: Action code 1 (broadcast) gives `out_bcast` = 1, `out_port` = 0, `out_drop` = 0 and `out_ttl` = input TTL − 1.
- R6: A miss, or a selected entry with action code 2 or 3, gives `out_drop` = 1, `out_bcast` = 0, `out_port` = 0 and the TTL unchanged.
- R7: An IPv4 header with TTL 0 or 1 is dropped with its TTL unchanged, whatever the table holds.
- R8: A header with `in_is_ipv4` = 0 is dropped with its TTL unchanged.
- R9: A write with `cfg_we` high takes effect at that clock edge. A header presented in the same cycle sees the old entry, and a header in the next cycle sees the new one. Writing `cfg_valid` = 0 removes the entry.
- R10: Reset leaves every entry invalid and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_prefix | input | 32 | Prefix address |
| cfg_len | input | 6 | Prefix length (values above 32 act as 32) |
| cfg_act | input | 2 | Action code: 0 forward, 1 broadcast, 2/3 drop |
| cfg_port | input | PORT_W | Egress port for forward |
| in_valid | input | 1 | Header valid |
| in_is_ipv4 | input | 1 | Header is IPv4 |
| in_dst | input | 32 | Destination address |
| in_ttl | input | 8 | Incoming TTL |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_port | output | PORT_W | Egress port |
| out_bcast | output | 1 | Broadcast egress |
| out_drop | output | 1 | Packet dropped |
| out_ttl | output | 8 | Updated TTL |

## Verification
The bench builds the stage with its defaults of eight entries and a four-bit port. With eight entries, a few overlapping prefixes can fill the table at once, so multi-hit ties, /0 defaults and /32 host routes all come up together. The six-bit length field lets the random stimulus write lengths above 32 to exercise the clamping. Random writes land in the same cycle as lookups, which exercises the old-contents rule at every write.

// File: rtl/ipv4_lpm_pkg.sv
package ipv4_lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;
  localparam int TTL_W  = 8;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_BCAST = 2'd1,
    ACT_DROP  = 2'd2,
    ACT_RSVD  = 2'd3
  } act_e;

  // Leading-ones mask; shifts of 32 or more saturate to all ones.
  function automatic logic [ADDR_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
    return ~({ADDR_W{1'b1}} >> len);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
    return (len > LEN_W'(ADDR_W)) ? LEN_W'(ADDR_W) : len;
  endfunction
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/lpm_table.sv
module lpm_table import ipv4_lpm_pkg::*; #(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [1:0]        wr_act,
  input  logic [PORT_W-1:0] wr_port,
  output logic              ent_valid  [N_ENTRIES],
  output logic [ADDR_W-1:0] ent_prefix [N_ENTRIES],
  output logic [LEN_W-1:0]  ent_len    [N_ENTRIES],
  output logic [1:0]        ent_act    [N_ENTRIES],
  output logic [PORT_W-1:0] ent_port   [N_ENTRIES]
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic sel_en;
    assign sel_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_valid[g] <= 1'b0;
      else if (sel_en) ent_valid[g] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel_en) begin
        ent_prefix[g] <= wr_prefix;
        ent_len[g]    <= wr_len;
        ent_act[g]    <= wr_act;
        ent_port[g]   <= wr_port;
      end
    end
  end
endmodule

// File: rtl/lpm_match.sv
module lpm_match import ipv4_lpm_pkg::*; #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [ADDR_W-1:0] key,
  input  logic              ent_valid  [N_ENTRIES],
  input  logic [ADDR_W-1:0] ent_prefix [N_ENTRIES],
  input  logic [LEN_W-1:0]  ent_len    [N_ENTRIES],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic             cand    [N_ENTRIES];
  logic [LEN_W-1:0] eff_len [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    assign mask       = prefix_mask(ent_len[g]);
    assign eff_len[g] = clamp_len(ent_len[g]);
    assign cand[g]    = ent_valid[g] && ((key & mask) == (ent_prefix[g] & mask));
  end

  logic [LEN_W-1:0] best_len;

  // Strictly-greater update keeps the lowest index on equal lengths.
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    best_len = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (cand[i] && (!hit || (eff_len[i] > best_len))) begin
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
        best_len = eff_len[i];
      end
    end
  end
endmodule

// File: rtl/lpm_action.sv
module lpm_action import ipv4_lpm_pkg::*; #(
  parameter int PORT_W = 4
) (
  input  logic              is_ipv4,
  input  logic [TTL_W-1:0]  ttl,
  input  logic              hit,
  input  logic [1:0]        act_raw,
  input  logic [PORT_W-1:0] ent_port,
  output logic [PORT_W-1:0] nxt_port,
  output logic              nxt_bcast,
  output logic              nxt_drop,
  output logic [TTL_W-1:0]  nxt_ttl
);
  act_e act;
  logic ttl_alive;

  assign act       = act_e'(act_raw);
  assign ttl_alive = (ttl > TTL_W'(1));

  always_comb begin
    nxt_port  = '0;
    nxt_bcast = 1'b0;
    nxt_drop  = 1'b1;
    nxt_ttl   = ttl;
    if (is_ipv4 && ttl_alive && hit) begin
      unique case (act)
        ACT_FWD: begin
          nxt_port = ent_port;
          nxt_drop = 1'b0;
          nxt_ttl  = ttl - TTL_W'(1);
        end
        ACT_BCAST: begin
          nxt_bcast = 1'b1;
          nxt_drop  = 1'b0;
          nxt_ttl   = ttl - TTL_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipv4_lpm_stage.sv
module ipv4_lpm_stage import ipv4_lpm_pkg::*; #(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [31:0]       cfg_prefix,
  input  logic [5:0]        cfg_len,
  input  logic [1:0]        cfg_act,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              in_valid,
  input  logic              in_is_ipv4,
  input  logic [31:0]       in_dst,
  input  logic [7:0]        in_ttl,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic              out_bcast,
  output logic              out_drop,
  output logic [7:0]        out_ttl
);
  logic rst_q_n;

  lpm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  logic              ent_valid  [N_ENTRIES];
  logic [ADDR_W-1:0] ent_prefix [N_ENTRIES];
  logic [LEN_W-1:0]  ent_len    [N_ENTRIES];
  logic [1:0]        ent_act    [N_ENTRIES];
  logic [PORT_W-1:0] ent_port   [N_ENTRIES];

  lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_prefix(cfg_prefix), .wr_len(cfg_len), .wr_act(cfg_act), .wr_port(cfg_port),
    .ent_valid(ent_valid), .ent_prefix(ent_prefix), .ent_len(ent_len),
    .ent_act(ent_act), .ent_port(ent_port)
  );

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .key(in_dst), .ent_valid(ent_valid), .ent_prefix(ent_prefix),
    .ent_len(ent_len), .hit(hit), .hit_idx(hit_idx)
  );

  logic [PORT_W-1:0] nxt_port;
  logic              nxt_bcast, nxt_drop;
  logic [TTL_W-1:0]  nxt_ttl;

  lpm_action #(.PORT_W(PORT_W)) u_action (
    .is_ipv4(in_is_ipv4), .ttl(in_ttl), .hit(hit),
    .act_raw(ent_act[hit_idx]), .ent_port(ent_port[hit_idx]),
    .nxt_port(nxt_port), .nxt_bcast(nxt_bcast), .nxt_drop(nxt_drop), .nxt_ttl(nxt_ttl)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) out_valid <= 1'b0;
    else          out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_port  <= nxt_port;
      out_bcast <= nxt_bcast;
      out_drop  <= nxt_drop;
      out_ttl   <= nxt_ttl;
    end
  end
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_is_ipv4,
  input logic [7:0]        in_ttl,
  input logic              out_valid,
  input logic [PORT_W-1:0] out_port,
  input logic              out_bcast,
  input logic              out_drop,
  input logic [7:0]        out_ttl
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  a_r6_drop_not_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_drop && out_bcast));

  a_r5_no_port_unless_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_drop || out_bcast)) |-> (out_port == '0));

  a_r4_ttl_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && !out_drop) |-> (out_ttl == $past(in_ttl) - 8'd1));

  a_r6_drop_keeps_ttl: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && out_drop) |-> (out_ttl == $past(in_ttl)));

  a_r7_low_ttl_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && in_ttl <= 8'd1)) |-> out_drop);

  a_r8_non_ipv4_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && !in_is_ipv4)) |-> out_drop);
endmodule

bind ipv4_lpm_stage lpm_checker #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .in_valid(in_valid), .in_is_ipv4(in_is_ipv4), .in_ttl(in_ttl),
  .out_valid(out_valid), .out_port(out_port), .out_bcast(out_bcast),
  .out_drop(out_drop), .out_ttl(out_ttl)
);

// File: tb/ipv4_lpm_stage_tb.sv
module ipv4_lpm_stage_tb;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic          cfg_we, cfg_valid;
  logic [IW-1:0] cfg_idx;
  logic [31:0]   cfg_prefix;
  logic [5:0]    cfg_len;
  logic [1:0]    cfg_act;
  logic [PW-1:0] cfg_port;
  logic          in_valid, in_is_ipv4;
  logic [31:0]   in_dst;
  logic [7:0]    in_ttl;
  logic          out_valid, out_bcast, out_drop;
  logic [PW-1:0] out_port;
  logic [7:0]    out_ttl;

  ipv4_lpm_stage #(.N_ENTRIES(N), .PORT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_prefix(cfg_prefix),
    .cfg_len(cfg_len), .cfg_act(cfg_act), .cfg_port(cfg_port),
    .in_valid(in_valid), .in_is_ipv4(in_is_ipv4), .in_dst(in_dst), .in_ttl(in_ttl),
    .out_valid(out_valid), .out_port(out_port), .out_bcast(out_bcast),
    .out_drop(out_drop), .out_ttl(out_ttl)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  bit        m_valid [N];
  bit [31:0] m_pfx   [N];
  bit [5:0]  m_len   [N];
  bit [1:0]  m_act   [N];
  bit [PW-1:0] m_port [N];

  bit          exp_v;
  bit [PW-1:0] exp_port;
  bit          exp_b, exp_d;
  bit [7:0]    exp_ttl;
  string       exp_tag;
  string       sect;

  function automatic bit [31:0] lead_mask(input bit [5:0] len);
    int l;
    l = (len > 6'd32) ? 32 : int'(len);
    return (l == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - l));
  endfunction

  task automatic predict();
    int best, best_len, nhit, l;
    best = -1; best_len = -1; nhit = 0;
    for (int i = 0; i < N; i++) begin
      l = (m_len[i] > 6'd32) ? 32 : int'(m_len[i]);
      if (m_valid[i] && ((in_dst & lead_mask(m_len[i])) == (m_pfx[i] & lead_mask(m_len[i])))) begin
        nhit++;
        if (l > best_len) begin best = i; best_len = l; end
      end
    end
    exp_v = in_valid; exp_port = '0; exp_b = 0; exp_d = 1; exp_ttl = in_ttl;
    if (!in_is_ipv4)            exp_tag = "R8";
    else if (in_ttl <= 8'd1)    exp_tag = "R7";
    else if (best < 0)          exp_tag = "R6";
    else begin
      exp_tag = (nhit > 1) ? "R3" : ((m_len[best] == 0 || m_len[best] > 32) ? "R2" : "R4");
      if (m_act[best] == 2'd0) begin
        exp_port = m_port[best]; exp_d = 0; exp_ttl = in_ttl - 8'd1;
      end else if (m_act[best] == 2'd1) begin
        exp_b = 1; exp_d = 0; exp_ttl = in_ttl - 8'd1;
        if (nhit == 1) exp_tag = "R5";
      end else if (nhit == 1) exp_tag = "R6";
    end
    if (cfg_we) begin
      m_valid[cfg_idx] = cfg_valid; m_pfx[cfg_idx] = cfg_prefix; m_len[cfg_idx] = cfg_len;
      m_act[cfg_idx] = cfg_act; m_port[cfg_idx] = cfg_port;
    end
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== exp_v) begin
      fails++;
      $display("FAIL %s/R1 out_valid act=%0b exp=%0b", sect, out_valid, exp_v);
    end else if (exp_v && (out_port !== exp_port || out_bcast !== exp_b ||
                           out_drop !== exp_d || out_ttl !== exp_ttl)) begin
      fails++;
      $display("FAIL %s/%s port/bcast/drop/ttl act=%0d/%0b/%0b/%0d exp=%0d/%0b/%0b/%0d",
               sect, exp_tag, out_port, out_bcast, out_drop, out_ttl,
               exp_port, exp_b, exp_d, exp_ttl);
    end
  endtask

  task automatic cycle();
    predict();
    @(negedge clk);
    check_out();
  endtask

  task automatic cfg(input int idx, input bit v, input bit [31:0] p, input bit [5:0] l,
                     input bit [1:0] a, input bit [PW-1:0] pt);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_prefix = p; cfg_len = l;
    cfg_act = a; cfg_port = pt; in_valid = 0;
    cycle();
    cfg_we = 0;
  endtask

  task automatic pkt(input bit [31:0] d, input bit [7:0] t, input bit ip);
    in_valid = 1; in_dst = d; in_ttl = t; in_is_ipv4 = ip;
    cycle();
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    cfg_we = 0; cfg_idx = '0; cfg_valid = 0; cfg_prefix = '0; cfg_len = '0;
    cfg_act = '0; cfg_port = '0; in_valid = 0; in_is_ipv4 = 1; in_dst = '0; in_ttl = '0;
    rst_n = 0;
    sect = "R10";
    repeat (3) @(negedge clk);
    exp_v = 0; check_out();
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_out();
    pkt(32'h0A01_0203, 8'd64, 1);           // empty table: drop

    sect = "R4";
    cfg(0, 1, 32'h0A01_0000, 6'd16, 2'd0, 4'd1);
    cfg(1, 1, 32'h0A02_0000, 6'd16, 2'd0, 4'd2);
    cfg(2, 1, 32'h0AFF_FFFF, 6'd32, 2'd1, 4'd7);
    pkt(32'h0A01_0506, 8'd64, 1);
    pkt(32'h0A02_0001, 8'd2, 1);
    sect = "R5";
    pkt(32'h0AFF_FFFF, 8'd10, 1);
    sect = "R6";
    pkt(32'h0AFF_FFFE, 8'd10, 1);

    sect = "R3";
    cfg(3, 1, 32'h0A00_0000, 6'd8, 2'd0, 4'd5);
    pkt(32'h0A01_7777, 8'd9, 1);
    pkt(32'h0A03_0000, 8'd9, 1);
    cfg(5, 1, 32'h0A03_0000, 6'd16, 2'd0, 4'd9);
    cfg(6, 1, 32'h0A03_0000, 6'd16, 2'd0, 4'd10);
    pkt(32'h0A03_0101, 8'd9, 1);

    sect = "R2";
    cfg(7, 1, 32'h0000_0000, 6'd0, 2'd0, 4'd12);
    pkt(32'h0808_0808, 8'd33, 1);
    cfg(4, 1, 32'h0808_0808, 6'd40, 2'd0, 4'd3);
    pkt(32'h0808_0808, 8'd33, 1);
    pkt(32'h0808_0809, 8'd33, 1);

    sect = "R7";
    pkt(32'h0A01_0001, 8'd1, 1);
    pkt(32'h0A01_0001, 8'd0, 1);
    sect = "R8";
    pkt(32'h0A01_0001, 8'd50, 0);
    sect = "R6";
    cfg(0, 1, 32'h0A01_0000, 6'd16, 2'd2, 4'd1);
    pkt(32'h0A01_0001, 8'd50, 1);

    sect = "R9";
    cfg_we = 1; cfg_idx = 3'd1; cfg_valid = 0; cfg_prefix = 32'h0A02_0000; cfg_len = 6'd16;
    cfg_act = 2'd0; cfg_port = 4'd2;
    pkt(32'h0A02_0001, 8'd20, 1);          // old entry: port 2
    cfg_we = 0;
    pkt(32'h0A02_0001, 8'd20, 1);          // entry removed: /8 gives port 5

    sect = "R1";
    in_valid = 1; in_is_ipv4 = 1;
    for (int k = 0; k < 6; k++) begin
      in_dst = 32'h0A00_0000 | (32'(k) << 16); in_ttl = 8'(k + 2);
      cycle();
    end
    in_valid = 0;
    cycle();

    sect = "RND";
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] bases [6];
      bases[0] = 32'h0A01_0000; bases[1] = 32'h0A02_0000; bases[2] = 32'h0A00_0000;
      bases[3] = 32'h0AFF_FFFF; bases[4] = 32'hC0A8_0100; bases[5] = $urandom;
      cfg_we     = ($urandom % 4) == 0;
      cfg_idx    = IW'($urandom);
      cfg_valid  = ($urandom % 5) != 0;
      cfg_prefix = bases[$urandom % 6];
      cfg_len    = 6'($urandom % 41);
      cfg_act    = 2'($urandom);
      cfg_port   = PW'($urandom);
      in_valid   = ($urandom % 8) != 0;
      in_is_ipv4 = ($urandom % 16) != 0;
      in_dst     = bases[$urandom % 6] ^ ($urandom >> ($urandom % 33));
      case ($urandom % 6)
        0: in_ttl = 8'd0;
        1: in_ttl = 8'd1;
        2: in_ttl = 8'd2;
        default: in_ttl = 8'($urandom);
      endcase
      cycle();
    end
    cfg_we = 0; in_valid = 0;
    cycle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule